// File: doc/BRIEF.md
# Operate-Group Microinstruction Unit

This unit carries out the single-cycle operate instructions of a 16-bit accumulator machine. One instruction word can request several micro-operations at once. Each one is picked by its own bit in the low byte of the word. The unit applies the selected operations in a fixed order of three time steps, all inside one clock cycle:

- Step one holds the clears.
- Step two holds the complements.
- Step three holds the increment, the OR-in of the front-panel switch register, and the set of the link.

The surrounding sequencer presents the following on the same edge, with `op_valid` high:

- the instruction word,
- the current accumulator,
- the link bit,
- the switch register,
- the program counter.

One cycle later it reads back the next accumulator, the next link, the next program counter and a halt request, all qualified by `op_done`. Results are held between instructions, so the sequencer may sample them at leisure.

Micro-operation bits, counted in the instruction word:

| Bit | Micro-operation |
|-----|-----------------|
| 0 | Clear accumulator |
| 1 | Complement accumulator |
| 2 (mask 004) | Increment accumulator |
| 3 | Clear link |
| 4 | Complement link |
| 5 (mask 040) | OR switch register into accumulator |
| 6 | Halt (clear the run flag) |
| 7 | Set link |

Bits 15 to 8 select the instruction group elsewhere and have no effect here.

Top module: `opr_unit`

## Requirements
- R1: A word presented with `op_valid` at a clock edge gives `op_done` high for exactly the following cycle. In that cycle `pc_out` equals `pc_in`+1 modulo 2^16, so 0xFFFF goes to 0x0000.
- R2: Bit 6 raises `halt_req` in the same cycle as `op_done`, and the program counter still advances by one. `halt_req` is never high without `op_done`.
- R3: Bit 2 adds one to the accumulator modulo 2^16, after the clear and the complement. A wrap from 0xFFFF to 0 leaves the link unchanged.
- R4: Bit 5 ORs `switches` into the accumulator in step three, after the increment. For example, AC=0xFFFF with bits 2 and 5 and switches 0x0005 gives 0x0005.
- R5: Bit 0 sets AC to 0 in step one, and bit 1 inverts all 16 bits in step two. With both set, the result is 0xFFFF.
- R6: Bit 3 clears the link in step one, bit 4 inverts it in step two, and bit 7 forces it to 1 in step three. Bits 3 and 4 together give 1.
- R7: Bits 0 and 3 together leave both AC and link at zero.
- R8: A word whose bits 7 to 0 are all zero passes AC and link through unchanged and requests no halt.
- R9: Bits 15 to 8 of the word have no effect on any output.
- R10: After reset all outputs are zero. While `op_valid` is low, `acc_out`, `link_out` and `pc_out` hold their values, and `op_done` and `halt_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction presented this cycle |
| op_word | input | 16 | Instruction word; bits 7..0 select micro-operations |
| acc_in | input | 16 | Current accumulator |
| link_in | input | 1 | Current link bit |
| switches | input | 16 | Front-panel data switch register |
| pc_in | input | 16 | Address of this instruction |
| acc_out | output | 16 | Next accumulator |
| link_out | output | 1 | Next link bit |
| pc_out | output | 16 | Next program counter |
| halt_req | output | 1 | Run flag must be cleared |
| op_done | output | 1 | Results valid, instruction complete |

## Verification
The increment and the switch OR share step three. Their order shows only when both bits are set and the increment carries across bits that the switches also drive. A directed case takes AC=0xFFFF with both bits set, so the increment wraps to zero before the OR. Further cases stack the clear, complement and increment on the same accumulator. Random words exercise every combination of the eight bits. Each result is judged against a bench model that applies the three steps by its own arithmetic.

// File: rtl/opr_pkg.sv
package opr_pkg;

  // Bit positions of the micro-operation selects inside the instruction word.
  localparam int unsigned SEL_CLR_AC  = 0;
  localparam int unsigned SEL_CPL_AC  = 1;
  localparam int unsigned SEL_INC_AC  = 2;
  localparam int unsigned SEL_CLR_LNK = 3;
  localparam int unsigned SEL_CPL_LNK = 4;
  localparam int unsigned SEL_OR_SW   = 5;
  localparam int unsigned SEL_HALT    = 6;
  localparam int unsigned SEL_SET_LNK = 7;
  localparam int unsigned MICRO_W     = 8;

  typedef struct packed {
    logic set_lnk;
    logic halt;
    logic or_sw;
    logic cpl_lnk;
    logic clr_lnk;
    logic inc_ac;
    logic cpl_ac;
    logic clr_ac;
  } opr_sel_t;

endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [MICRO_W-1:0] micro,
  output opr_sel_t           sel
);
  always_comb begin
    sel.clr_ac  = micro[SEL_CLR_AC];
    sel.cpl_ac  = micro[SEL_CPL_AC];
    sel.inc_ac  = micro[SEL_INC_AC];
    sel.clr_lnk = micro[SEL_CLR_LNK];
    sel.cpl_lnk = micro[SEL_CPL_LNK];
    sel.or_sw   = micro[SEL_OR_SW];
    sel.halt    = micro[SEL_HALT];
    sel.set_lnk = micro[SEL_SET_LNK];
  end
endmodule

// File: rtl/opr_step_clear.sv
// Time step one: clears.
module opr_step_clear #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clr_ac,
  input  logic              clr_lnk,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              lnk_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              lnk_o
);
  always_comb begin
    acc_o = clr_ac  ? '0   : acc_i;
    lnk_o = clr_lnk ? 1'b0 : lnk_i;
  end
endmodule

// File: rtl/opr_step_compl.sv
// Time step two: complements.
module opr_step_compl #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              cpl_ac,
  input  logic              cpl_lnk,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              lnk_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              lnk_o
);
  always_comb begin
    acc_o = cpl_ac  ? ~acc_i : acc_i;
    lnk_o = cpl_lnk ? ~lnk_i : lnk_i;
  end
endmodule

// File: rtl/opr_step_late.sv
// Time step three: increment, then switch OR-in; link set.
module opr_step_late #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              inc_ac,
  input  logic              or_sw,
  input  logic              set_lnk,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              lnk_i,
  input  logic [DATA_W-1:0] sw,
  output logic [DATA_W-1:0] acc_o,
  output logic              lnk_o,
  output logic [DATA_W-1:0] acc_after_inc
);
  // Increment modulo 2^DATA_W; the carry out is dropped and never reaches the link.
  function automatic logic [DATA_W-1:0] f_wrap_inc(input logic [DATA_W-1:0] v);
    logic [DATA_W:0] wide;
    wide = {1'b0, v} + {{DATA_W{1'b0}}, 1'b1};
    return wide[DATA_W-1:0];
  endfunction

  always_comb begin
    acc_after_inc = inc_ac ? f_wrap_inc(acc_i) : acc_i;
    acc_o         = or_sw ? (acc_after_inc | sw) : acc_after_inc;
    lnk_o         = set_lnk | lnk_i;
  end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] op_word,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              link_in,
  input  logic [DATA_W-1:0] switches,
  input  logic [PC_W-1:0]   pc_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              link_out,
  output logic [PC_W-1:0]   pc_out,
  output logic              halt_req,
  output logic              op_done
);
  localparam int unsigned HI_W = WORD_W - MICRO_W;

  opr_sel_t          sel;
  logic [HI_W-1:0]   unused_group_bits;
  logic [DATA_W-1:0] acc_t1, acc_t2, acc_t3, acc_inc_stage;
  logic              lnk_t1, lnk_t2, lnk_t3;
  logic [PC_W-1:0]   pc_next;

  // Group-select bits belong to another decoder.
  assign unused_group_bits = op_word[WORD_W-1:MICRO_W];

  opr_decode u_dec (.micro(op_word[MICRO_W-1:0]), .sel(sel));

  opr_step_clear #(.DATA_W(DATA_W)) u_t1 (
    .clr_ac(sel.clr_ac), .clr_lnk(sel.clr_lnk),
    .acc_i(acc_in), .lnk_i(link_in), .acc_o(acc_t1), .lnk_o(lnk_t1));

  opr_step_compl #(.DATA_W(DATA_W)) u_t2 (
    .cpl_ac(sel.cpl_ac), .cpl_lnk(sel.cpl_lnk),
    .acc_i(acc_t1), .lnk_i(lnk_t1), .acc_o(acc_t2), .lnk_o(lnk_t2));

  opr_step_late #(.DATA_W(DATA_W)) u_t3 (
    .inc_ac(sel.inc_ac), .or_sw(sel.or_sw), .set_lnk(sel.set_lnk),
    .acc_i(acc_t2), .lnk_i(lnk_t2), .sw(switches),
    .acc_o(acc_t3), .lnk_o(lnk_t3), .acc_after_inc(acc_inc_stage));

  function automatic logic [PC_W-1:0] f_pc_step(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  assign pc_next = f_pc_step(pc_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out  <= '0;
      link_out <= 1'b0;
      pc_out   <= '0;
      halt_req <= 1'b0;
      op_done  <= 1'b0;
    end else begin
      op_done  <= op_valid;
      halt_req <= op_valid & sel.halt;
      if (op_valid) begin
        acc_out  <= acc_t3;
        link_out <= lnk_t3;
        pc_out   <= pc_next;
      end
    end
  end

  // ---------------- assertions ----------------
  p_done_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> op_done);
  p_pc_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> pc_out == PC_W'($past(pc_in) + PC_W'(1)));
  p_halt_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_word[SEL_HALT]) |=> halt_req);
  p_halt_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> op_done);
  p_inc_no_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_word[MICRO_W-1:0] == MICRO_W'(1 << SEL_INC_AC))
      |=> link_out == $past(link_in));
  p_sw_on_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sel.or_sw) |=> ((acc_out & $past(switches)) == $past(switches)));
  p_clear_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_word[MICRO_W-1:0] ==
       MICRO_W'((1 << SEL_CLR_AC) | (1 << SEL_CLR_LNK)))
      |=> (acc_out == '0 && !link_out));
  p_nop_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_word[MICRO_W-1:0] == '0)
      |=> (acc_out == $past(acc_in) && link_out == $past(link_in) && !halt_req));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_out) && $stable(link_out) && $stable(pc_out)
                   && !op_done && !halt_req));
endmodule

// File: tb/tb_opr_unit.sv
`timescale 1ns/1ps
module tb_opr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] op_word = '0, acc_in = '0, switches = '0, pc_in = '0;
  logic        link_in = 1'b0;
  logic [15:0] acc_out, pc_out;
  logic        link_out, halt_req, op_done;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  opr_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .acc_in(acc_in), .link_in(link_in), .switches(switches), .pc_in(pc_in),
    .acc_out(acc_out), .link_out(link_out), .pc_out(pc_out),
    .halt_req(halt_req), .op_done(op_done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model: {link, acc} after the three steps.
  function automatic logic [16:0] model(input logic [15:0] w, input logic [15:0] a,
                                        input logic l, input logic [15:0] s);
    int unsigned acc;
    bit lk;
    acc = a; lk = l;
    if (w[0]) acc = 0;
    if (w[3]) lk = 0;
    if (w[1]) acc = 32'hFFFF - acc;
    if (w[4]) lk = (lk == 0);
    if (w[2]) acc = (acc + 1) % 65536;
    if (w[5]) acc = acc | s;
    if (w[7]) lk = 1;
    return {lk, acc[15:0]};
  endfunction

  task automatic run_op(input logic [15:0] w, input logic [15:0] a, input logic l,
                        input logic [15:0] s, input logic [15:0] pc, input string req);
    logic [16:0] e;
    logic [15:0] epc;
    e = model(w, a, l, s);
    epc = pc + 16'd1;
    @(negedge clk);
    op_valid = 1'b1; op_word = w; acc_in = a; link_in = l; switches = s; pc_in = pc;
    @(negedge clk);
    op_valid = 1'b0;
    chk(acc_out == e[15:0], req, acc_out, e[15:0]);
    chk(link_out == e[16], req, link_out, e[16]);
    chk(op_done == 1'b1, {req, " R1 done"}, op_done, 1);
    chk(pc_out == epc, {req, " R1 pc"}, pc_out, epc);
    chk(halt_req == w[6], {req, " R2 halt"}, halt_req, w[6]);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20150612));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(acc_out == 0 && link_out == 0 && pc_out == 0 && !op_done && !halt_req,
        "R10 reset", {acc_out, 15'b0, link_out}, 0);
    rst_n = 1'b1;

    run_op(16'h0000, 16'h1234, 1'b1, 16'hFFFF, 16'h0040, "R8 nop");
    run_op(16'hFF00, 16'h0A5A, 1'b0, 16'hFFFF, 16'h0041, "R9 upper bits ignored");
    run_op(16'h0001, 16'h1234, 1'b1, 16'h0000, 16'h0042, "R5 clear ac");
    run_op(16'h0002, 16'h0000, 1'b0, 16'h0000, 16'h0043, "R5 complement ac");
    run_op(16'h0003, 16'h4321, 1'b0, 16'h0000, 16'h0044, "R5 clear then complement");
    run_op(16'h0004, 16'h0001, 1'b0, 16'h0000, 16'h0045, "R3 increment");
    run_op(16'h0004, 16'hFFFF, 1'b0, 16'h0000, 16'h0046, "R3 increment wrap link kept 0");
    run_op(16'h0004, 16'hFFFF, 1'b1, 16'h0000, 16'h0047, "R3 increment wrap link kept 1");
    run_op(16'h0006, 16'h0000, 1'b0, 16'h0000, 16'h0048, "R3 complement then increment");
    run_op(16'h0020, 16'h00FF, 1'b0, 16'hF000, 16'h0049, "R4 switch or");
    run_op(16'h0024, 16'hFFFF, 1'b0, 16'h0005, 16'h004A, "R4 increment before or");
    run_op(16'h0008, 16'h0000, 1'b1, 16'h0000, 16'h004B, "R6 clear link");
    run_op(16'h0010, 16'h0000, 1'b0, 16'h0000, 16'h004C, "R6 complement link");
    run_op(16'h0018, 16'h0000, 1'b1, 16'h0000, 16'h004D, "R6 clear then complement link");
    run_op(16'h0080, 16'h0000, 1'b0, 16'h0000, 16'h004E, "R6 set link");
    run_op(16'h0090, 16'h0000, 1'b0, 16'h0000, 16'h004F, "R6 set after complement");
    run_op(16'h0009, 16'hFFFF, 1'b1, 16'h0000, 16'h0050, "R7 clear both");
    run_op(16'h0040, 16'h0777, 1'b1, 16'h0000, 16'hFFFF, "R2 halt with pc wrap R1");

    // R10 hold while idle
    @(negedge clk);
    chk(acc_out == 16'h0777 && link_out == 1'b1, "R10 hold acc/link", {acc_out, 15'b0, link_out}, {16'h0777, 16'h0001});
    chk(pc_out == 16'h0000 && !op_done && !halt_req, "R10 idle pc/done/halt", {pc_out, 14'b0, op_done, halt_req}, 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w, a, s, pc;
      logic l;
      w  = 16'($urandom);
      a  = 16'($urandom);
      s  = 16'($urandom);
      pc = 16'($urandom);
      l  = 1'($urandom);
      if (i % 8 == 0) a = 16'hFFFF;
      run_op(w, a, l, s, pc, "R3 R4 R5 R6 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule